// File: doc/BRIEF.md
# Buffered Host Bus Slave

This block sits between a host processor and a word-wide shared RAM plus a small register file. The host opens a cycle by pulling a strobe low while its chip select is also low, and a memory/register input steers the access to RAM or to the registers. One register stage samples all host inputs on the system clock. The block answers with a ready handshake that has two timing flavours, chosen by a strap.

Strap inputs configure the host side. The data path is either 16 bits wide or 8 bits wide. In 8-bit mode two byte accesses make up one stored word. The sense of the read/write line, the sense of the byte-select line and the order of the two bytes in a pair are all set by straps. The address can either be captured when the cycle opens or followed live until the internal access is issued. The straps are expected to change only while no cycle is in progress.

Top module: `hostbus_slave`

## Requirements
- R1: A cycle starts only when `strobe_n` and `select_n` are both low. Either one low on its own leaves `ready` at 0 and changes no stored word.
- R2: `mem_sel`=1 reaches the RAM word at the full address. `mem_sel`=0 reaches register number `addr[log2(REG_N)-1:0]`, which is storage separate from the RAM.
- R3: In 16-bit mode (`cfg_wide`=1) the access is a read when `rd_wr` equals `cfg_pol` and a write otherwise.
- R4: In 8-bit mode `rd_wr`=1 means read. The byte lane is high when `byte_sel` XOR `cfg_pol` is 1. Write bytes come from `wdata[7:0]`, and read bytes appear on `rdata[7:0]` with `rdata[15:8]`=0.
- R5: In 8-bit mode the first byte of a pair is the high lane when `cfg_hi_first`=1 and the low lane when it is 0. A first-byte write changes no stored word. The second-byte write stores the held first byte together with the second byte as one word.
- R6: In zero-wait mode (`cfg_nz_wait`=0), `ready` stays 0 while the strobe is held. It rises only after the strobe is released and stays high for exactly two clock cycles. Read data is on `rdata` before `ready` falls.
- R7: In nonzero-wait mode (`cfg_nz_wait`=1), once `ready` is high it stays high until the strobe release is seen, and it falls on the next clock.
- R8: In nonzero-wait mode, `rdata` holds the requested read data whenever `ready` is high, and a write has already been stored by the time `ready` rises.
- R9: With `cfg_addr_pass`=0 the address present when the cycle opens is used. With `cfg_addr_pass`=1 the address present when the internal access is issued is used (in zero-wait mode, at strobe release).
- R10: In zero-wait mode, a strobe that is asserted while `ready` is still high is not accepted until the two-cycle transfer has finished, and it then completes as a normal cycle.
- R11: An 8-bit second-byte read returns the other byte of the word snapshot taken at the most recent first-byte read, regardless of its own address.
- R12: After reset `ready`=0, `rdata`=0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 = 16-bit data path, 0 = 8-bit byte pairs |
| cfg_pol | input | 1 | Polarity strap for the read/write line (16-bit) or the byte-select line (8-bit) |
| cfg_hi_first | input | 1 | 1 = high byte first in a pair |
| cfg_nz_wait | input | 1 | 1 = nonzero-wait handshake, 0 = zero-wait |
| cfg_addr_pass | input | 1 | 1 = address followed live, 0 = address captured |
| strobe_n | input | 1 | Active-low data strobe |
| select_n | input | 1 | Active-low chip select |
| mem_sel | input | 1 | 1 = RAM, 0 = register file |
| rd_wr | input | 1 | Read/write line, sense set by straps |
| byte_sel | input | 1 | Byte lane line for 8-bit mode |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data (registered) |
| ready | output | 1 | Transfer handshake (registered) |

## Verification
On every cycle the assertions check the handshake shape: no cycle starts from idle unless both strobe and select are low, the zero-wait pulse is two cycles long and follows the release, the nonzero-wait ready stays high until release, and no internal access is issued while ready is high. They also check that the two zero-wait transfer states run in a fixed order and that a first-byte write never reaches storage. Only the bench scenarios can show where the data goes. These cover the polarity and byte-order straps across all combinations, register aliasing against the RAM, latched versus live address, the snapshot source of a second-byte read, and a strobe held off during a busy transfer that still lands its data.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NZ_ISSUE,
    ST_NZ_READ,
    ST_NZ_HOLD,
    ST_ZW_OPEN,
    ST_ZW_X1,
    ST_ZW_X2
  } hb_state_t;

  // Decoded meaning of one host access
  typedef struct packed {
    logic is_read;
    logic is_mem;
    logic hi_lane;
    logic first;
  } hb_req_t;

  function automatic logic [7:0] pick_lane(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/hostbus_decode.sv
module hostbus_decode
  import hostbus_pkg::*;
(
  input  logic    cfg_wide,
  input  logic    cfg_pol,
  input  logic    cfg_hi_first,
  input  logic    rd_wr,
  input  logic    byte_sel,
  input  logic    mem_sel,
  output hb_req_t req
);

  always_comb begin
    req.is_mem  = mem_sel;
    // lane sense flips with the polarity strap
    req.hi_lane = byte_sel ^ cfg_pol;
    req.first   = (req.hi_lane == cfg_hi_first);
    // wide path: strap picks read level; byte path: high is read
    req.is_read = cfg_wide ? (rd_wr == cfg_pol) : rd_wr;
  end

endmodule

// File: rtl/hostbus_store.sv
module hostbus_store #(
  parameter int ADDR_W = 12,
  parameter int REG_N  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic              is_mem,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int REG_AW = (REG_N > 1) ? $clog2(REG_N) : 1;

  logic [15:0]       ram [DEPTH];
  logic [15:0]       ram_q;
  logic [15:0]       regs [REG_N];
  logic [15:0]       reg_q;
  logic              mem_q;
  logic [REG_AW-1:0] ridx;

  assign ridx = addr[REG_AW-1:0];

  // single-port, read-first RAM: block RAM friendly
  always_ff @(posedge clk) begin
    if (en && is_mem) begin
      if (we) ram[addr] <= wdata;
      ram_q <= ram[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
    end else if (en && we && !is_mem) begin
      for (int i = 0; i < REG_N; i++)
        if (ridx == REG_AW'(i)) regs[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
      mem_q <= 1'b0;
    end else if (en) begin
      mem_q <= is_mem;
      if (!is_mem) reg_q <= regs[ridx];
    end
  end

  assign rdata = mem_q ? ram_q : reg_q;

  AST_REG_LANDS: assert property (@(posedge clk) disable iff (rst)
    (en && we && !is_mem) |=> (regs[$past(ridx)] == $past(wdata))); // R2

endmodule

// File: rtl/hostbus_bytes.sv
module hostbus_bytes
  import hostbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wide,
  input  hb_req_t     req,
  input  logic        issue,
  input  logic        rdata_we,
  input  logic [15:0] wdata,
  input  logic [15:0] store_rdata,
  output logic        need_store,
  output logic [15:0] wr_word,
  output logic [15:0] rd_value
);

  logic [7:0]  hold_b;
  logic [15:0] snap;
  logic        hold_we;
  logic        snap_we;

  assign hold_we = issue && !cfg_wide && !req.is_read && req.first;
  assign snap_we = rdata_we && !cfg_wide && req.is_read && req.first;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_b <= '0;
      snap   <= '0;
    end else begin
      if (hold_we) hold_b <= wdata[7:0];
      if (snap_we) snap   <= store_rdata;
    end
  end

  // byte pairs touch storage once: first read, second write
  assign need_store = cfg_wide || (req.is_read ? req.first : !req.first);

  assign wr_word = cfg_wide    ? wdata :
                   req.hi_lane ? {wdata[7:0], hold_b} : {hold_b, wdata[7:0]};

  assign rd_value = cfg_wide ? store_rdata :
                    {8'h00, pick_lane(req.first ? store_rdata : snap, req.hi_lane)};

endmodule

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
  import hostbus_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_nz_wait,
  input  logic              cfg_addr_pass,
  input  logic              active,
  input  hb_req_t           req_in,
  input  logic [ADDR_W-1:0] addr_in,
  output hb_req_t           req_l,
  output logic [ADDR_W-1:0] st_addr,
  output logic              issue,
  output logic              rdata_we,
  output logic              ready
);

  hb_state_t         state;
  logic [ADDR_W-1:0] addr_l;

  always_comb begin
    issue    = 1'b0;
    rdata_we = 1'b0;
    case (state)
      ST_NZ_ISSUE: issue    = 1'b1;
      ST_NZ_READ:  rdata_we = 1'b1;
      ST_ZW_OPEN:  issue    = !active;
      ST_ZW_X1:    rdata_we = req_l.is_read;
      default: ;
    endcase
  end

  assign st_addr = cfg_addr_pass ? addr_in : addr_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ready  <= 1'b0;
      addr_l <= '0;
      req_l  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (active) begin
          addr_l <= addr_in;
          req_l  <= req_in;
          state  <= cfg_nz_wait ? ST_NZ_ISSUE : ST_ZW_OPEN;
        end
        ST_NZ_ISSUE: begin
          if (req_l.is_read) state <= ST_NZ_READ;
          else begin
            state <= ST_NZ_HOLD;
            ready <= 1'b1;
          end
        end
        ST_NZ_READ: begin
          state <= ST_NZ_HOLD;
          ready <= 1'b1;
        end
        ST_NZ_HOLD: if (!active) begin
          state <= ST_IDLE;
          ready <= 1'b0;
        end
        ST_ZW_OPEN: if (!active) begin
          state <= ST_ZW_X1;
          ready <= 1'b1;
        end
        ST_ZW_X1: state <= ST_ZW_X2;
        ST_ZW_X2: begin
          state <= ST_IDLE;
          ready <= 1'b0;
        end
        default: begin
          state <= ST_IDLE;
          ready <= 1'b0;
        end
      endcase
    end
  end

  AST_IDLE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !active) |=> (state == ST_IDLE)); // R1
  AST_ZW_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_nz_wait && $rose(ready)) |-> !$past(active)); // R6
  AST_ZW_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    (!cfg_nz_wait && $rose(ready)) |=> ready ##1 !ready); // R6
  AST_NZ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_nz_wait && ready && active) |=> ready); // R7
  AST_NZ_DROP: assert property (@(posedge clk) disable iff (rst)
    (cfg_nz_wait && ready && !active) |=> !ready); // R7
  AST_ZW_ORDER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ZW_X1) |=> (state == ST_ZW_X2)); // R10
  AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (rst)
    ready |-> !issue); // R10

endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hostbus_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int REG_N  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wide,
  input  logic              cfg_pol,
  input  logic              cfg_hi_first,
  input  logic              cfg_nz_wait,
  input  logic              cfg_addr_pass,
  input  logic              strobe_n,
  input  logic              select_n,
  input  logic              mem_sel,
  input  logic              rd_wr,
  input  logic              byte_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              ready
);

  logic              strobe_q, select_q, mem_q, rw_q, bsel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic              active;
  hb_req_t           req_now, req_l;
  logic [ADDR_W-1:0] st_addr;
  logic              issue, rdata_we, need_store, st_en, st_we;
  logic [15:0]       wr_word, rd_value, store_rdata;

  // one input register stage on every host line
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b1;
      select_q <= 1'b1;
      mem_q    <= 1'b0;
      rw_q     <= 1'b0;
      bsel_q   <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      strobe_q <= strobe_n;
      select_q <= select_n;
      mem_q    <= mem_sel;
      rw_q     <= rd_wr;
      bsel_q   <= byte_sel;
      addr_q   <= addr;
      wdata_q  <= wdata;
    end
  end

  assign active = !strobe_q && !select_q;

  hostbus_decode u_dec (
    .cfg_wide     (cfg_wide),
    .cfg_pol      (cfg_pol),
    .cfg_hi_first (cfg_hi_first),
    .rd_wr        (rw_q),
    .byte_sel     (bsel_q),
    .mem_sel      (mem_q),
    .req          (req_now)
  );

  hostbus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .cfg_nz_wait   (cfg_nz_wait),
    .cfg_addr_pass (cfg_addr_pass),
    .active        (active),
    .req_in        (req_now),
    .addr_in       (addr_q),
    .req_l         (req_l),
    .st_addr       (st_addr),
    .issue         (issue),
    .rdata_we      (rdata_we),
    .ready         (ready)
  );

  hostbus_bytes u_bytes (
    .clk         (clk),
    .rst         (rst),
    .cfg_wide    (cfg_wide),
    .req         (req_l),
    .issue       (issue),
    .rdata_we    (rdata_we),
    .wdata       (wdata_q),
    .store_rdata (store_rdata),
    .need_store  (need_store),
    .wr_word     (wr_word),
    .rd_value    (rd_value)
  );

  assign st_en = issue && need_store;
  assign st_we = !req_l.is_read;

  hostbus_store #(.ADDR_W(ADDR_W), .REG_N(REG_N)) u_store (
    .clk    (clk),
    .rst    (rst),
    .en     (st_en),
    .we     (st_we),
    .is_mem (req_l.is_mem),
    .addr   (st_addr),
    .wdata  (wr_word),
    .rdata  (store_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)           rdata <= '0;
    else if (rdata_we) rdata <= rd_value;
  end

  AST_FIRST_BYTE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (issue && !cfg_wide && !req_l.is_read && req_l.first) |-> !st_en); // R5

endmodule

// File: tb/sim_hostbus_slave.sv
module sim_hostbus_slave;

  localparam int AW = 6;
  localparam int RN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wide = 1'b1, cfg_pol = 1'b1, cfg_hi_first = 1'b1;
  logic cfg_nz_wait = 1'b1, cfg_addr_pass = 1'b0;
  logic strobe_n = 1'b1, select_n = 1'b1, mem_sel = 1'b0, rd_wr = 1'b0, byte_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ready;

  int checks = 0;
  int failures = 0;

  logic [15:0] mdl_mem [1<<AW];
  logic [15:0] mdl_reg [RN];

  always #10 clk = ~clk;

  hostbus_slave #(.ADDR_W(AW), .REG_N(RN)) u0 (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_pol(cfg_pol),
    .cfg_hi_first(cfg_hi_first), .cfg_nz_wait(cfg_nz_wait),
    .cfg_addr_pass(cfg_addr_pass), .strobe_n(strobe_n), .select_n(select_n),
    .mem_sel(mem_sel), .rd_wr(rd_wr), .byte_sel(byte_sel), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  // one host cycle; strap-level pins are given raw
  task automatic xfer(input logic m, input logic rw, input logic bs,
                      input logic [AW-1:0] a, input logic [15:0] d,
                      output logic [15:0] r);
    int n;
    int hi;
    @(negedge clk);
    mem_sel = m; rd_wr = rw; byte_sel = bs; addr = a; wdata = d;
    strobe_n = 1'b0; select_n = 1'b0;
    r = '0;
    if (cfg_nz_wait) begin
      n = 0;
      while (!ready && n < 40) begin @(negedge clk); n++; end
      chk("R8 ready rise", 16'(ready), 16'd1);
      r = rdata;
      @(negedge clk);
      chk("R7 ready held", 16'(ready), 16'd1);
      strobe_n = 1'b1; select_n = 1'b1;
      n = 0;
      while (ready && n < 40) begin @(negedge clk); n++; end
    end else begin
      repeat (2) @(negedge clk);
      chk("R6 no ready while strobe", 16'(ready), 16'd0);
      strobe_n = 1'b1; select_n = 1'b1;
      n = 0;
      while (!ready && n < 40) begin @(negedge clk); n++; end
      hi = 0;
      while (ready && hi < 40) begin @(negedge clk); hi++; end
      chk("R6 pulse length", 16'(hi), 16'd2);
      r = rdata;
    end
    @(negedge clk);
  endtask

  function automatic logic rw_pin(input logic rd);
    return cfg_wide ? (rd ? cfg_pol : !cfg_pol) : rd;
  endfunction

  function automatic logic bs_pin(input logic hi);
    return hi ^ cfg_pol;
  endfunction

  task automatic wr_word(input logic m, input logic [AW-1:0] a, input logic [15:0] d);
    logic [15:0] r;
    if (cfg_wide) xfer(m, rw_pin(1'b0), 1'b0, a, d, r);
    else begin
      xfer(m, 1'b0, bs_pin(cfg_hi_first), a, {8'h00, cfg_hi_first ? d[15:8] : d[7:0]}, r);
      xfer(m, 1'b0, bs_pin(!cfg_hi_first), a, {8'h00, cfg_hi_first ? d[7:0] : d[15:8]}, r);
    end
    if (m) mdl_mem[a] = d;
    else   mdl_reg[a % RN] = d;
  endtask

  task automatic rd_word(input logic m, input logic [AW-1:0] a, output logic [15:0] d);
    logic [15:0] r1, r2;
    if (cfg_wide) xfer(m, rw_pin(1'b1), 1'b0, a, 16'h0, d);
    else begin
      xfer(m, 1'b1, bs_pin(cfg_hi_first), a, 16'h0, r1);
      xfer(m, 1'b1, bs_pin(!cfg_hi_first), a, 16'h0, r2);
      chk("R4 upper byte zero", {r1[15:8], r2[15:8]}, 16'h0);
      d = cfg_hi_first ? {r1[7:0], r2[7:0]} : {r2[7:0], r1[7:0]};
    end
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] r;
    for (int i = 0; i < RN; i++) mdl_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 ready", 16'(ready), 16'd0);
    chk("R12 rdata", rdata, 16'h0);
    for (int i = 0; i < RN; i++) begin
      rd_word(1'b0, AW'(i), v);
      chk("R12 register", v, 16'h0);
    end

    // R1 strobe without select, then select without strobe
    @(negedge clk);
    mem_sel = 1'b0; rd_wr = rw_pin(1'b0); addr = AW'(1); wdata = 16'hDEAD;
    strobe_n = 1'b0; select_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 strobe only", 16'(ready), 16'd0);
    strobe_n = 1'b1; select_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 select only", 16'(ready), 16'd0);
    select_n = 1'b1;
    rd_word(1'b0, AW'(1), v);
    chk("R1 no write", v, 16'h0);

    // sweep all strap combinations: R2 R3 R4 R5 R6 R7 R8
    for (int cfgi = 0; cfgi < 16; cfgi++) begin
      @(negedge clk);
      cfg_wide = cfgi[0]; cfg_pol = cfgi[1];
      cfg_hi_first = cfgi[2]; cfg_nz_wait = cfgi[3];
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] a;
        a = AW'((cfgi * 4 + k * 17) % (1 << AW));
        wr_word(1'b1, a, 16'hA5C3 ^ 16'(cfgi << 8) ^ 16'(k * 16'h1111) ^ 16'(a));
      end
      for (int k = 0; k < RN; k++)
        wr_word(1'b0, AW'(k | ((cfgi & 15) << 2)), 16'h0F0F ^ 16'(cfgi * 16'h0321) ^ 16'(k));
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] a;
        a = AW'((cfgi * 4 + k * 17) % (1 << AW));
        rd_word(1'b1, a, v);
        chk(cfg_wide ? "R3 R2 ram word" : "R4 R5 ram word", v, mdl_mem[a]);
      end
      for (int k = 0; k < RN; k++) begin
        rd_word(1'b0, AW'(k + RN), v);
        chk(cfg_wide ? "R3 R2 register" : "R4 R5 register", v, mdl_reg[k]);
      end
    end

    // R5 a lone first byte stores nothing; second completes the word
    @(negedge clk);
    cfg_wide = 1'b0; cfg_pol = 1'b0; cfg_hi_first = 1'b1; cfg_nz_wait = 1'b1;
    wr_word(1'b1, AW'(9), 16'h1234);
    xfer(1'b1, 1'b0, bs_pin(1'b1), AW'(9), 16'h00AB, r);
    rd_word(1'b1, AW'(9), v);
    chk("R5 first byte alone", v, 16'h1234);
    xfer(1'b1, 1'b0, bs_pin(1'b0), AW'(9), 16'h00CD, r);
    rd_word(1'b1, AW'(9), v);
    chk("R5 pair commit", v, 16'hABCD);

    // R11 second byte comes from snapshot, not its own address
    wr_word(1'b1, AW'(20), 16'h5566);
    wr_word(1'b1, AW'(21), 16'h7788);
    xfer(1'b1, 1'b1, bs_pin(1'b1), AW'(20), 16'h0, r);
    chk("R11 first byte", r, 16'h0055);
    xfer(1'b1, 1'b1, bs_pin(1'b0), AW'(21), 16'h0, r);
    chk("R11 snapshot byte", r, 16'h0066);

    // R9 latched versus live address, zero-wait, 16-bit
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      cfg_wide = 1'b1; cfg_pol = 1'b1; cfg_nz_wait = 1'b0; cfg_addr_pass = 1'b0;
      wr_word(1'b1, AW'(30), 16'h0000);
      wr_word(1'b1, AW'(31), 16'h0000);
      cfg_addr_pass = p[0];
      @(negedge clk);
      mem_sel = 1'b1; rd_wr = rw_pin(1'b0); addr = AW'(30); wdata = 16'hBEEF;
      strobe_n = 1'b0; select_n = 1'b0;
      repeat (2) @(negedge clk);
      addr = AW'(31);
      repeat (2) @(negedge clk);
      strobe_n = 1'b1; select_n = 1'b1;
      repeat (8) @(negedge clk);
      cfg_addr_pass = 1'b0;
      rd_word(1'b1, AW'(30), v);
      chk("R9 captured addr", v, p ? 16'h0000 : 16'hBEEF);
      rd_word(1'b1, AW'(31), v);
      chk("R9 live addr", v, p ? 16'hBEEF : 16'h0000);
    end

    // R10 strobe during the zero-wait transfer is held off, then completes
    @(negedge clk);
    mem_sel = 1'b1; rd_wr = rw_pin(1'b0); addr = AW'(40); wdata = 16'h1111;
    strobe_n = 1'b0; select_n = 1'b0;
    repeat (2) @(negedge clk);
    strobe_n = 1'b1; select_n = 1'b1;
    for (int n = 0; n < 40 && !ready; n++) @(negedge clk);
    addr = AW'(41); wdata = 16'h2222;
    strobe_n = 1'b0; select_n = 1'b0;
    repeat (4) @(negedge clk);
    strobe_n = 1'b1; select_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 idle after both", 16'(ready), 16'd0);
    rd_word(1'b1, AW'(40), v);
    chk("R10 first write", v, 16'h1111);
    rd_word(1'b1, AW'(41), v);
    chk("R10 held-off write", v, 16'h2222);

    finish_run();
  end

endmodule